// File: doc/BRIEF.md
# Passive Serial Configuration Host

This block is the host side of a passive configuration link. It loads a bitstream into a target device that waits for its configuration data. The block drives an active-low configuration request toward the target and generates the target's configuration clock. It watches the target's active-low status line and its done line. Bitstream bytes come in from an upstream valid/ready stream. The last byte carries a marker.

A start pulse begins the sequence:

1. The block pulls the request low for a fixed number of system clocks, which returns the target to its unconfigured state.
2. It waits until the status line has gone low and then high again.
3. It shifts the stream out, one bit per configuration clock or one 8/16-bit unit per clock, chosen by a parameter.
4. It keeps the configuration clock running until the target raises done.

If the status line drops while the block is sending, or done never arrives within a bounded number of extra clocks, the block stops and reports an error with its cause. A new start from the success or error state runs the whole sequence again.

Top module: `cfgl_host`

## Requirements
- R1: A start pulse in the idle, success or error state drives `cfg_req_n` low for exactly REQ_CYC system clock cycles (default 8). `busy` is high from the cycle after the start is sampled.
- R2: After `cfg_req_n` is released, no configuration clock edge is issued and `s_ready` stays low until `tgt_status_n` has been seen low and then high.
- R3: The configuration clock comes only from this block. It has a period of DIV system cycles (DIV at least 2) and is high for DIV - DIV/2 cycles of each period. It rests low whenever the block is not sending data or waiting for done.
- R4: In serial mode (DATA_W = 1), each byte is sent least significant bit first, one bit per rising clock edge, with bytes in stream order.
- R5: `cfg_data` changes only when the configuration clock falls, so it is stable during every high phase.
- R6: In 16-bit parallel mode, each rising edge carries two stream bytes, with the earlier byte in bits 7:0 and the later byte in bits 15:8. In 8-bit mode, each edge carries one byte.
- R7: `s_ready` is high only while data is being sent, the shifter is empty and `tgt_status_n` is high. In every other state it stays low even when `s_valid` is high, and no byte is taken.
- R8: If `tgt_status_n` goes low while data is being sent, the block goes to error with `err` = 1 and `err_timeout` = 0. The configuration clock then stops low and `s_ready` stays low.
- R9: After the final data unit, the clock keeps running until `tgt_done` is seen high. The block then raises `ok` and drops `busy`.
- R10: If `tgt_done` is still low after EXTRA_CLK extra rising edges (default 64) following the final data unit, the block reports `err` = 1 with `err_timeout` = 1. Exactly EXTRA_CLK extra edges are issued.
- R11: A start from the success or error state clears `ok`, `err` and `err_timeout` and repeats the sequence from R1.
- R12: After reset, `cfg_req_n` is high, the configuration clock is low, and `s_ready`, `busy`, `ok` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration run |
| s_valid | input | 1 | Upstream byte valid |
| s_ready | output | 1 | Upstream byte accepted this cycle when valid |
| s_data | input | 8 | Upstream bitstream byte |
| s_last | input | 1 | Marks the final byte of the bitstream |
| cfg_req_n | output | 1 | Active-low configuration request to the target |
| cfg_clk | output | 1 | Configuration clock to the target |
| cfg_data | output | DATA_W | Configuration data to the target |
| tgt_status_n | input | 1 | Target active-low status (ready / error) |
| tgt_done | input | 1 | Target reports configuration complete |
| busy | output | 1 | A run is in progress |
| ok | output | 1 | Last run finished successfully |
| err | output | 1 | Last run ended in an error |
| err_timeout | output | 1 | Error cause: 1 = done timeout, 0 = status dropped |

## Verification
The assertions assume that `tgt_status_n` and `tgt_done` are synchronous to `clk`. They also assume that upstream holds `s_data` and `s_last` steady while `s_valid` waits for `s_ready`. The bench meets both conditions: it changes every input only on the falling system clock edge and keeps each byte on the bus until the edge that accepts it. It plays the target itself. It pulls status low only while the request is asserted or at one chosen point during the data phase. It raises done only after the last data unit has gone out.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET_PULSE,
        ST_WAIT_READY,
        ST_STREAM,
        ST_WAIT_DONE,
        ST_DONE,
        ST_ERROR
    } cfgl_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } cfgl_tick_t;

    function automatic int unsigned shift_width(int unsigned dw);
        return (dw < BYTE_W) ? BYTE_W : dw;
    endfunction

endpackage

// File: rtl/cfgl_clkgen.sv
module cfgl_clkgen
    import cfgl_pkg::*;
#(
    parameter int unsigned DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    output logic       cclk,
    output cfgl_tick_t tick
);
    localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int unsigned HALF = DIV / 2;

    logic [CW-1:0] cnt;

    always_comb begin
        tick.rise = en && (cnt == CW'(HALF - 1));
        tick.fall = en && (cnt == CW'(DIV - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            cclk <= 1'b0;
        end else begin
            cnt <= tick.fall ? '0 : cnt + 1'b1;
            if (tick.rise)      cclk <= 1'b1;
            else if (tick.fall) cclk <= 1'b0;
        end
    end

    AST_CLK_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(cclk) |-> $past(en)) else $error("clock rose while disabled"); // R3

endmodule

// File: rtl/cfgl_shifter.sv
module cfgl_shifter
    import cfgl_pkg::*;
#(
    parameter int unsigned DATA_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              take,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  logic              fall,
    output logic              full,
    output logic              last_end,
    output logic [DATA_W-1:0] data_out
);
    localparam int unsigned SH_W  = shift_width(DATA_W);
    localparam int unsigned BYTES = SH_W / BYTE_W;
    localparam int unsigned UNITS = SH_W / DATA_W;
    localparam int unsigned UW    = $clog2(UNITS + 1);
    localparam int unsigned BW    = (BYTES > 1) ? $clog2(BYTES) : 1;

    logic [SH_W-1:0] sh, acc, word_next;
    logic [UW-1:0]   units;
    logic [BW-1:0]   bidx;
    logic            last_q, load;

    always_comb begin
        word_next = acc;
        for (int b = 0; b < BYTES; b++) begin
            if (BW'(b) == bidx) word_next[b*BYTE_W +: BYTE_W] = in_data;
        end
        load = take && ((bidx == BW'(BYTES - 1)) || in_last);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh     <= '0;
            acc    <= '0;
            units  <= '0;
            bidx   <= '0;
            last_q <= 1'b0;
        end else if (take) begin
            if (load) begin
                sh     <= word_next;
                units  <= UW'(UNITS);
                last_q <= in_last;
                acc    <= '0;
                bidx   <= '0;
            end else begin
                acc  <= word_next;
                bidx <= bidx + 1'b1;
            end
        end else if (fall && full) begin
            sh    <= sh >> DATA_W;
            units <= units - 1'b1;
        end
    end

    assign full     = (units != '0);
    assign last_end = fall && (units == UW'(1)) && last_q;
    assign data_out = sh[DATA_W-1:0];

    AST_HOLD_UNTIL_FALL: assert property (@(posedge clk) disable iff (rst)
        (full && !fall && !clr) |=> $stable(data_out)) else $error("data moved off the falling edge"); // R5

endmodule

// File: rtl/cfgl_seq.sv
module cfgl_seq
    import cfgl_pkg::*;
#(
    parameter int unsigned REQ_CYC   = 8,
    parameter int unsigned EXTRA_CLK = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        status_n,
    input  logic        done,
    input  logic        last_end,
    input  cfgl_tick_t  tick,
    output cfgl_state_e state,
    output logic        err_timeout
);
    localparam int unsigned RW = $clog2(REQ_CYC + 1);
    localparam int unsigned EW = $clog2(EXTRA_CLK + 1);

    logic [RW-1:0] rcnt;
    logic [EW-1:0] ecnt;
    logic          seen_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            rcnt        <= '0;
            ecnt        <= '0;
            seen_low    <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE, ST_ERROR: begin
                    if (start) begin
                        state       <= ST_RESET_PULSE;
                        rcnt        <= '0;
                        err_timeout <= 1'b0;
                    end
                end
                ST_RESET_PULSE: begin
                    rcnt <= rcnt + 1'b1;
                    if (rcnt == RW'(REQ_CYC - 1)) begin
                        state    <= ST_WAIT_READY;
                        seen_low <= 1'b0;
                    end
                end
                ST_WAIT_READY: begin
                    if (!status_n)     seen_low <= 1'b1;
                    else if (seen_low) state    <= ST_STREAM;
                end
                ST_STREAM: begin
                    if (!status_n) begin
                        state       <= ST_ERROR;
                        err_timeout <= 1'b0;
                    end else if (last_end) begin
                        state <= ST_WAIT_DONE;
                        ecnt  <= '0;
                    end
                end
                ST_WAIT_DONE: begin
                    if (!status_n) begin
                        state       <= ST_ERROR;
                        err_timeout <= 1'b0;
                    end else if (done) begin
                        state <= ST_DONE;
                    end else if (tick.fall && ecnt == EW'(EXTRA_CLK)) begin
                        state       <= ST_ERROR;
                        err_timeout <= 1'b1;
                    end else if (tick.rise && ecnt != EW'(EXTRA_CLK)) begin
                        ecnt <= ecnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_STATUS_DROP_ERR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STREAM && !status_n) |=> (state == ST_ERROR && !err_timeout)) else $error("status drop not reported"); // R8

endmodule

// File: rtl/cfgl_host.sv
module cfgl_host
    import cfgl_pkg::*;
#(
    parameter int unsigned DATA_W    = 1,
    parameter int unsigned DIV       = 4,
    parameter int unsigned REQ_CYC   = 8,
    parameter int unsigned EXTRA_CLK = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    output logic              cfg_req_n,
    output logic              cfg_clk,
    output logic [DATA_W-1:0] cfg_data,
    input  logic              tgt_status_n,
    input  logic              tgt_done,
    output logic              busy,
    output logic              ok,
    output logic              err,
    output logic              err_timeout
);
    cfgl_state_e state;
    cfgl_tick_t  tick;
    logic        full, last_end, clk_en, take;

    assign clk_en    = (state == ST_STREAM && full) || (state == ST_WAIT_DONE);
    assign s_ready   = (state == ST_STREAM) && !full && tgt_status_n;
    assign take      = s_valid && s_ready;
    assign cfg_req_n = (state != ST_RESET_PULSE);
    assign busy      = !(state inside {ST_IDLE, ST_DONE, ST_ERROR});
    assign ok        = (state == ST_DONE);
    assign err       = (state == ST_ERROR);

    cfgl_clkgen #(.DIV(DIV)) clkgen_i (
        .clk  (clk),
        .rst  (rst),
        .en   (clk_en),
        .cclk (cfg_clk),
        .tick (tick)
    );

    cfgl_shifter #(.DATA_W(DATA_W)) shifter_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (state != ST_STREAM),
        .take     (take),
        .in_data  (s_data),
        .in_last  (s_last),
        .fall     (tick.fall),
        .full     (full),
        .last_end (last_end),
        .data_out (cfg_data)
    );

    cfgl_seq #(.REQ_CYC(REQ_CYC), .EXTRA_CLK(EXTRA_CLK)) seq_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .status_n    (tgt_status_n),
        .done        (tgt_done),
        .last_end    (last_end),
        .tick        (tick),
        .state       (state),
        .err_timeout (err_timeout)
    );

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (cfg_clk && $past(cfg_clk)) |-> $stable(cfg_data)) else $error("data changed while clock high"); // R5

    AST_READY_CLOCK_IDLE: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> !cfg_clk) else $error("ready while clock running"); // R7

    AST_OK_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(ok) |-> $past(tgt_done)) else $error("success without done"); // R9

endmodule

// File: tb/cfgl_host_tb.sv
module cfgl_host_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int n_total = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // serial DUT
    logic       start = 0, s_valid = 0, s_last = 0;
    logic [7:0] s_data = '0;
    logic       s_ready, cfg_req_n, cfg_clk, busy, ok, err, err_timeout;
    logic [0:0] cfg_data;
    logic       tgt_status_n = 1, tgt_done = 0;

    cfgl_host #(.DATA_W(1), .DIV(4), .REQ_CYC(8), .EXTRA_CLK(64)) dut_i (
        .clk(clk), .rst(rst), .start(start), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_last(s_last), .cfg_req_n(cfg_req_n), .cfg_clk(cfg_clk),
        .cfg_data(cfg_data), .tgt_status_n(tgt_status_n), .tgt_done(tgt_done),
        .busy(busy), .ok(ok), .err(err), .err_timeout(err_timeout)
    );

    // 16-bit parallel DUT
    logic        p_start = 0, p_valid = 0, p_last = 0;
    logic [7:0]  p_sdata = '0;
    logic        p_ready, p_req_n, p_cclk, p_busy, p_ok, p_err, p_tmo;
    logic [15:0] p_cdata;
    logic        p_status_n = 1, p_done = 0;

    cfgl_host #(.DATA_W(16), .DIV(2), .REQ_CYC(4), .EXTRA_CLK(8)) dut_p (
        .clk(clk), .rst(rst), .start(p_start), .s_valid(p_valid), .s_ready(p_ready),
        .s_data(p_sdata), .s_last(p_last), .cfg_req_n(p_req_n), .cfg_clk(p_cclk),
        .cfg_data(p_cdata), .tgt_status_n(p_status_n), .tgt_done(p_done),
        .busy(p_busy), .ok(p_ok), .err(p_err), .err_timeout(p_tmo)
    );

    // target models
    logic        rx_bits [512];
    int          rx_n = 0;
    logic [15:0] rx_w [16];
    int          rxp_n = 0;
    always @(posedge cfg_clk) begin
        if (rx_n < 512) rx_bits[rx_n] = cfg_data[0];
        rx_n = rx_n + 1;
    end
    always @(posedge p_cclk) begin
        if (rxp_n < 16) rx_w[rxp_n] = p_cdata;
        rxp_n = rxp_n + 1;
    end

    // observers
    int   req_low = 0, hw_run = 0, hw_bad = 0, stab_bad = 0;
    logic prev_clk = 0;
    logic prev_dat = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!cfg_req_n) req_low = req_low + 1;
            if (cfg_clk) hw_run = hw_run + 1;
            else begin
                if (hw_run != 0 && hw_run != 2) hw_bad = hw_bad + 1;
                hw_run = 0;
            end
            if (cfg_clk && prev_clk && cfg_data[0] != prev_dat) stab_bad = stab_bad + 1;
            prev_clk = cfg_clk;
            prev_dat = cfg_data[0];
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            n_total = n_total + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
        n_total = n_total + 1;
        if (!cond) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rx_byte(input int k);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[i] = rx_bits[8*k + i];
        return b;
    endfunction

    task automatic push(input logic [7:0] b, input logic last);
        @(negedge clk);
        s_valid = 1; s_data = b; s_last = last;
        while (!s_ready) @(negedge clk);
        @(posedge clk); #1;
        s_valid = 0; s_last = 0;
    endtask

    task automatic begin_cfg();
        int bad;
        req_low = 0;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        chk(busy && !ok && !err && !err_timeout, "R11", "flags after start", {busy, ok, err, err_timeout}, 4'b1000);
        chk(!cfg_req_n, "R1", "request asserted", cfg_req_n, 0);
        tgt_status_n = 0; tgt_done = 0;
        while (!cfg_req_n) @(negedge clk);
        chk(req_low == 8, "R1", "request low cycles", req_low, 8);
        rx_n = 0;
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (s_ready || cfg_clk || rx_n != 0) bad++;
        end
        chk(bad == 0, "R2", "quiet before status high", bad, 0);
        tgt_status_n = 1;
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(cfg_req_n && !cfg_clk && !s_ready && !busy && !ok && !err, "R12", "reset outputs",
            {cfg_req_n, cfg_clk, s_ready, busy, ok, err}, 6'b100000);
    endtask

    task automatic test_idle_ignore();
        int bad = 0;
        s_valid = 1; s_data = 8'hEE;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (s_ready || cfg_clk) bad++;
        end
        s_valid = 0;
        chk(bad == 0, "R7", "ready low in idle", bad, 0);
    endtask

    task automatic test_serial_ok();
        logic [7:0] bytes [4] = '{8'hA5, 8'h3C, 8'h01, 8'h80};
        hw_bad = 0; stab_bad = 0;
        begin_cfg();
        for (int k = 0; k < 4; k++) push(bytes[k], k == 3);
        while (rx_n < 32 + 5) @(negedge clk);
        tgt_done = 1;
        repeat (3) @(negedge clk);
        chk(ok && !err && !busy, "R9", "success flags", {ok, err, busy}, 3'b100);
        for (int k = 0; k < 4; k++)
            chk(rx_byte(k) == bytes[k], "R4", "serial byte LSB first", rx_byte(k), bytes[k]);
        repeat (5) @(negedge clk);
        chk(!cfg_clk, "R3", "clock parked low after done", cfg_clk, 0);
        chk(hw_bad == 0, "R3", "high phase width", hw_bad, 0);
        chk(stab_bad == 0, "R5", "data stable while clock high", stab_bad, 0);
    endtask

    task automatic test_timeout();
        int guard = 0;
        begin_cfg();
        push(8'h5A, 0);
        push(8'hC3, 1);
        while (!err && guard < 3000) begin @(negedge clk); guard++; end
        chk(err && err_timeout && !busy, "R10", "timeout error", {err, err_timeout, busy}, 3'b110);
        chk(rx_n == 16 + 64, "R10", "rising edges incl extra", rx_n, 80);
        chk(rx_byte(0) == 8'h5A && rx_byte(1) == 8'hC3, "R4", "bytes before timeout",
            {rx_byte(0), rx_byte(1)}, 16'h5AC3);
    endtask

    task automatic test_status_err();
        int n0, bad;
        begin_cfg();
        push(8'hA7, 0);
        while (rx_n < 3) @(negedge clk);
        tgt_status_n = 0;
        repeat (2) @(negedge clk);
        chk(err && !err_timeout, "R8", "status drop error", {err, err_timeout}, 2'b10);
        n0 = rx_n; bad = 0;
        s_valid = 1; s_data = 8'hFF;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cfg_clk || s_ready) bad++;
        end
        s_valid = 0;
        chk(bad == 0, "R8", "clock and ready stopped", bad, 0);
        chk(rx_n == n0, "R8", "no further edges", rx_n, n0);
        tgt_status_n = 1;
    endtask

    task automatic test_parallel();
        logic [7:0] pb [4] = '{8'h12, 8'h34, 8'hAB, 8'hCD};
        @(negedge clk) p_start = 1;
        @(negedge clk) p_start = 0;
        p_status_n = 0;
        while (!p_req_n) @(negedge clk);
        rxp_n = 0;
        repeat (3) @(negedge clk);
        p_status_n = 1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            p_valid = 1; p_sdata = pb[k]; p_last = (k == 3);
            while (!p_ready) @(negedge clk);
            @(posedge clk); #1;
            p_valid = 0; p_last = 0;
        end
        while (rxp_n < 3) @(negedge clk);
        p_done = 1;
        repeat (3) @(negedge clk);
        chk(p_ok && !p_err, "R9", "parallel success", {p_ok, p_err}, 2'b10);
        chk(rx_w[0] == 16'h3412, "R6", "first word", rx_w[0], 16'h3412);
        chk(rx_w[1] == 16'hCDAB, "R6", "second word", rx_w[1], 16'hCDAB);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 0;
        test_reset();
        test_idle_ignore();
        test_serial_ok();
        test_timeout();
        test_status_err();
        test_parallel();
        summary();
        $finish;
    end

endmodule